// File: doc/BRIEF.md
# Partial Statistics Variance Aggregator

This block merges a run of partial statistics into the mean and the population variance of the whole population. Each partial result is a triple of words: how many samples the subset held, the subset mean, and the subset population variance already multiplied by that sample count. Because the variance terms arrive pre-scaled by their counts, the merge is a plain sum of moments. The division by the total count happens once, after the final triple.

Words enter one per beat on a valid/ready stream. A last flag marks the final word of a set. After the set closes, the block computes a reciprocal of the total count with an iterative unit. It then multiplies through to form the two results, and offers them on a second valid/ready stream: the mean first, then the variance. Every word uses one signed fixed-point format. Sideband flags mark a malformed set and an empty (zero-count) set. Input is held off from the closing word until the second result word is taken, and the accumulators restart empty for the next set.

Top module: `psa_aggregator`

## Requirements
- R1: Every input word is a W-bit two's-complement value with F fraction bits (defaults W=16, F=8). A set is a run of triples in the order count, mean, scaled variance. The count of a triple is the integer field word[W-2:F] of its word, and the fraction bits of that word are dropped.
- R2: in_ready is 1 while a set is being collected. It is 0 from the cycle after the last-flagged word is accepted until the second result word is accepted.
- R3: Each set yields exactly two result words: the mean with out_last=0, then the variance with out_last=1. While out_valid=1 and out_ready=0, the word and its flags hold steady.
- R4: With N = Σcount, S1 = Σcount·mean (F fraction bits) and R = floor(2^32 / N), the mean word is floor(S1·R / 2^32).
- R5: With S2 = Σ(scaled_variance·2^F + count·mean²) (2F fraction bits) and D = S2 − N·m², where m is the R4 mean word, the variance word is floor(D·R / 2^(32+F)), clamped to the range 0 to 2^(W−1)−1.
- R6: A set whose last-flagged word is not the third word of a triple is malformed. Both result words are 0 and out_err=1.
- R7: A count word with its sign bit set makes the set malformed. Both result words are 0 and out_err=1.
- R8: A well-formed set with N = 0 yields two zero words with out_zero=1 and out_err=0. No division takes place.
- R9: After the second result word is accepted, all running sums restart from zero, so the next set's results depend only on that set's words.
- R10: After reset, out_valid=0 and in_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in_valid | input | 1 | input word offered |
| in_ready | output | 1 | input word taken on this edge when valid |
| in_word | input | W | count, mean or scaled-variance word |
| in_last | input | 1 | marks the closing word of a set |
| out_valid | output | 1 | result word offered |
| out_ready | input | 1 | consumer takes the result word |
| out_word | output | W | mean, then variance |
| out_last | output | 1 | set on the variance word |
| out_err | output | 1 | set was malformed |
| out_zero | output | 1 | set had total count zero |

## Verification
A wrong word-position counter shows on the very next set. Either out_err rises for a correctly framed set, or the mean and variance come out of misassigned triples. A stale running sum after a result is taken only shows as a wrong mean in the following set, so sets are run back to back with no reset between them. A faulty reciprocal shifts both result words of the same set. Directed sets with exact quarter-unit answers and a saturating spread pin this down, and random sets cover the rest.

// File: rtl/psa_pkg.sv
package psa_pkg;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_DECIDE,
        ST_RECIP,
        ST_MEAN,
        ST_VAR,
        ST_EMIT0,
        ST_EMIT1
    } psa_state_e;

    typedef enum logic [1:0] {
        POS_CNT,
        POS_MEAN,
        POS_NVAR
    } psa_pos_e;

    typedef struct packed {
        logic err;
        logic zero;
    } psa_flags_t;

    function automatic int unsigned count_int_bits(int unsigned w, int unsigned f);
        return w - f - 1;
    endfunction

endpackage

// File: rtl/psa_accum.sv
module psa_accum
    import psa_pkg::*;
#(
    parameter int W        = 16,
    parameter int F        = 8,
    parameter int TUP_LOG2 = 6,
    localparam int CI      = W - F - 1,
    localparam int NW      = CI + TUP_LOG2,
    localparam int S1W     = W + CI + TUP_LOG2 + 1,
    localparam int S2W     = 2 * W + CI + TUP_LOG2 + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  accept,
    input  logic [W-1:0]          word,
    input  logic                  last,
    output logic                  err,
    output logic [NW-1:0]         n_tot,
    output logic signed [S1W-1:0] s1,
    output logic signed [S2W-1:0] s2
);

    psa_pos_e              pos_q;
    logic [CI-1:0]         cnt_q;
    logic signed [W-1:0]   mean_q;
    logic signed [CI:0]    cnt_s;
    logic signed [S1W-1:0] cm;
    logic signed [S2W-1:0] msq;
    logic signed [S2W-1:0] cm2;
    logic signed [S2W-1:0] nv_s;

    always_comb begin
        cnt_s = $signed({1'b0, cnt_q});
        cm    = S1W'(cnt_s) * S1W'(mean_q);
        msq   = S2W'(mean_q) * S2W'(mean_q);
        cm2   = S2W'(cnt_s) * msq;
        nv_s  = S2W'($signed(word)) <<< F;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q  <= POS_CNT;
            cnt_q  <= '0;
            mean_q <= '0;
            err    <= 1'b0;
            n_tot  <= '0;
            s1     <= '0;
            s2     <= '0;
        end else if (accept) begin
            unique case (pos_q)
                POS_CNT: begin
                    cnt_q <= word[W-2:F];
                    if (word[W-1]) err <= 1'b1;
                    if (last) begin
                        err   <= 1'b1;
                        pos_q <= POS_CNT;
                    end else begin
                        pos_q <= POS_MEAN;
                    end
                end
                POS_MEAN: begin
                    mean_q <= $signed(word);
                    if (last) begin
                        err   <= 1'b1;
                        pos_q <= POS_CNT;
                    end else begin
                        pos_q <= POS_NVAR;
                    end
                end
                POS_NVAR: begin
                    n_tot <= n_tot + NW'(cnt_q);
                    s1    <= s1 + cm;
                    s2    <= s2 + cm2 + nv_s;
                    pos_q <= POS_CNT;
                end
                default: pos_q <= POS_CNT;
            endcase
        end
    end

    // R1: the word position never leaves the three triple slots
    a_r1_pos_legal: assert property (@(posedge clk) disable iff (rst)
        pos_q == POS_CNT || pos_q == POS_MEAN || pos_q == POS_NVAR);

    // R9: a clear empties the running sums on the next cycle
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (n_tot == '0 && s1 == '0 && s2 == '0 && !err));

endmodule

// File: rtl/psa_recip.sv
module psa_recip #(
    parameter int NW = 13,
    parameter int RS = 32,
    localparam int IW = $clog2(RS + 1),
    localparam int CW = RS + NW + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] den,
    output logic          done,
    output logic [RS:0]   quo
);

    logic          busy;
    logic [IW-1:0] idx;
    logic [NW-1:0] rem;
    logic [NW-1:0] den_q;
    logic          bit_in;
    logic [NW:0]   trial;
    logic          ge;
    logic [NW-1:0] rem_nx;

    always_comb begin
        bit_in = (idx == IW'(RS));
        trial  = {rem, bit_in};
        ge     = trial >= {1'b0, den_q};
        rem_nx = ge ? NW'(trial - {1'b0, den_q}) : NW'(trial);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            rem   <= '0;
            den_q <= '0;
            quo   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                idx   <= IW'(RS);
                rem   <= '0;
                quo   <= '0;
                den_q <= den;
            end else if (busy) begin
                rem <= rem_nx;
                quo <= {quo[RS-1:0], ge};
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx - 1'b1;
                end
            end
        end
    end

    // R4: the reciprocal is the exact floor of 2^RS over the count
    a_r4_recip_exact: assert property (@(posedge clk) disable iff (rst)
        done |-> ((CW'(quo) * CW'(den_q) <= (CW'(1) << RS)) &&
                  ((CW'(quo) + CW'(1)) * CW'(den_q) > (CW'(1) << RS))));

endmodule

// File: rtl/psa_finish.sv
module psa_finish #(
    parameter int W   = 16,
    parameter int F   = 8,
    parameter int NW  = 13,
    parameter int S1W = 30,
    parameter int S2W = 46,
    parameter int RS  = 32,
    localparam int PW = S2W + RS + 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_mean,
    input  logic                  ld_var,
    input  logic [NW-1:0]         n_tot,
    input  logic signed [S1W-1:0] s1,
    input  logic signed [S2W-1:0] s2,
    input  logic [RS:0]           recip,
    output logic signed [W-1:0]   mean_o,
    output logic [W-1:0]          var_o
);

    localparam logic signed [PW-1:0] VMAX = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};

    logic signed [RS+1:0] rx;
    logic signed [PW-1:0] prod_m;
    logic signed [PW-1:0] msq;
    logic signed [PW-1:0] nm2;
    logic signed [PW-1:0] dev;
    logic signed [PW-1:0] prod_v;
    logic signed [PW-1:0] vfull;
    logic [W-1:0]         var_nx;

    always_comb begin
        rx     = $signed({1'b0, recip});
        prod_m = PW'(s1) * PW'(rx);
        msq    = PW'(mean_o) * PW'(mean_o);
        nm2    = PW'($signed({1'b0, n_tot})) * msq;
        dev    = PW'(s2) - nm2;
        prod_v = dev * PW'(rx);
        vfull  = prod_v >>> (RS + F);
        if (vfull < 0)         var_nx = '0;
        else if (vfull > VMAX) var_nx = W'(VMAX);
        else                   var_nx = W'(vfull);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mean_o <= '0;
            var_o  <= '0;
        end else begin
            if (ld_mean) mean_o <= W'(prod_m >>> RS);
            if (ld_var)  var_o  <= var_nx;
        end
    end

    // R5: a freshly loaded variance is never negative
    a_r5_var_nonneg: assert property (@(posedge clk) disable iff (rst)
        ld_var |=> !var_o[W-1]);

endmodule

// File: rtl/psa_aggregator.sv
module psa_aggregator
    import psa_pkg::*;
#(
    parameter int W        = 16,
    parameter int F        = 8,
    parameter int TUP_LOG2 = 6,
    parameter int RS       = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_word,
    input  logic         in_last,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_word,
    output logic         out_last,
    output logic         out_err,
    output logic         out_zero
);

    localparam int CI  = W - F - 1;
    localparam int NW  = CI + TUP_LOG2;
    localparam int S1W = W + CI + TUP_LOG2 + 1;
    localparam int S2W = 2 * W + CI + TUP_LOG2 + 1;

    psa_state_e            st_q;
    psa_flags_t            flg_q;
    logic                  accept;
    logic                  clr;
    logic                  acc_err;
    logic [NW-1:0]         n_tot;
    logic signed [S1W-1:0] s1;
    logic signed [S2W-1:0] s2;
    logic                  r_start;
    logic                  r_done;
    logic [RS:0]           recip;
    logic signed [W-1:0]   mean_w;
    logic [W-1:0]          var_w;

    assign in_ready  = (st_q == ST_COLLECT);
    assign accept    = in_valid && in_ready;
    assign out_valid = (st_q == ST_EMIT0) || (st_q == ST_EMIT1);
    assign out_last  = (st_q == ST_EMIT1);
    assign out_err   = out_valid && flg_q.err;
    assign out_zero  = out_valid && flg_q.zero;
    assign clr       = (st_q == ST_EMIT1) && out_ready;
    assign r_start   = (st_q == ST_DECIDE) && !acc_err && (n_tot != '0);

    always_comb begin
        if (!out_valid || flg_q.err || flg_q.zero) out_word = '0;
        else if (st_q == ST_EMIT0)                 out_word = mean_w;
        else                                       out_word = var_w;
    end

    psa_accum #(.W(W), .F(F), .TUP_LOG2(TUP_LOG2)) acc_i (
        .clk(clk), .rst(rst), .clr(clr), .accept(accept),
        .word(in_word), .last(in_last),
        .err(acc_err), .n_tot(n_tot), .s1(s1), .s2(s2)
    );

    psa_recip #(.NW(NW), .RS(RS)) rcp_i (
        .clk(clk), .rst(rst), .start(r_start), .den(n_tot),
        .done(r_done), .quo(recip)
    );

    psa_finish #(.W(W), .F(F), .NW(NW), .S1W(S1W), .S2W(S2W), .RS(RS)) fin_i (
        .clk(clk), .rst(rst),
        .ld_mean(st_q == ST_MEAN), .ld_var(st_q == ST_VAR),
        .n_tot(n_tot), .s1(s1), .s2(s2), .recip(recip),
        .mean_o(mean_w), .var_o(var_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_COLLECT;
            flg_q <= '0;
        end else begin
            unique case (st_q)
                ST_COLLECT: if (accept && in_last) st_q <= ST_DECIDE;
                ST_DECIDE: begin
                    flg_q.err  <= acc_err;
                    flg_q.zero <= !acc_err && (n_tot == '0);
                    st_q       <= r_start ? ST_RECIP : ST_EMIT0;
                end
                ST_RECIP:  if (r_done) st_q <= ST_MEAN;
                ST_MEAN:   st_q <= ST_VAR;
                ST_VAR:    st_q <= ST_EMIT0;
                ST_EMIT0:  if (out_ready) st_q <= ST_EMIT1;
                ST_EMIT1:  if (out_ready) st_q <= ST_COLLECT;
                default:   st_q <= ST_COLLECT;
            endcase
        end
    end

    // R2: no input is taken while a result is pending
    a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R3: a stalled result word and its flags stay put
    a_r3_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) &&
                                       $stable(out_last) && $stable(out_err)));

    // R3: the variance word always follows the mean word
    a_r3_order: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last && out_ready) |=> (out_valid && out_last));

    // R6 / R7: a malformed set carries zero words and no empty flag
    a_r6_err_zero: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_word == '0 && !out_zero));

    // R8: an empty set carries zero words
    a_r8_zero_words: assert property (@(posedge clk) disable iff (rst)
        out_zero |-> out_word == '0);

    // R5: the variance word is never negative
    a_r5_var_sign: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> !out_word[W-1]);

endmodule

// File: tb/psa_aggregator_tb_top.sv
module psa_aggregator_tb_top;

    localparam int W  = 16;
    localparam int F  = 8;
    localparam int RS = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [W-1:0] in_word;
    logic         in_last;
    logic         out_valid;
    logic         out_ready;
    logic [W-1:0] out_word;
    logic         out_last;
    logic         out_err;
    logic         out_zero;

    always #10 clk = ~clk;

    psa_aggregator dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .out_last(out_last), .out_err(out_err), .out_zero(out_zero)
    );

    int n_chk;
    int n_fail;
    bit finished;
    int tc [64];
    int tm [64];
    int tv [64];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void expect_res(input int nt, output int em, output int ev,
                                       output bit zero);
        logic signed [127:0] n, s1, s2, r, m, d, v, c, mu, nv;
        n = 0; s1 = 0; s2 = 0;
        for (int i = 0; i < nt; i++) begin
            c  = 128'(tc[i]);
            mu = 128'(tm[i]);
            nv = 128'(tv[i]);
            n  = n + c;
            s1 = s1 + c * mu;
            s2 = s2 + (nv <<< F) + c * mu * mu;
        end
        zero = (n == 0);
        if (zero) begin
            em = 0; ev = 0;
        end else begin
            r = (128'sd1 <<< RS) / n;
            m = (s1 * r) >>> RS;
            d = s2 - n * m * m;
            v = (d * r) >>> (RS + F);
            if (v < 0) v = 0;
            if (v > 32767) v = 32767;
            em = int'(m);
            ev = int'(v);
        end
    endfunction

    task automatic send_set(input int nt, input int extra);
        int nw;
        nw = 3 * nt + extra;
        for (int k = 0; k < nw; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_last  = (k == nw - 1);
            case (k % 3)
                0:       in_word = 16'(tc[k/3] <<< F);
                1:       in_word = 16'(tm[k/3]);
                default: in_word = 16'(tv[k/3]);
            endcase
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(in_ready == 1'b0, "R2", "in_ready after closing word", in_ready, 0);
    endtask

    task automatic run_set(input int nt, input int extra, input bit exp_err, input string tag);
        logic [W-1:0] w [2];
        bit e [2];
        bit z [2];
        bit l [2];
        int k;
        int guard;
        int em, ev;
        bit ez;
        send_set(nt, extra);
        k = 0;
        guard = 0;
        while (k < 2 && guard < 3000) begin
            out_ready = ($urandom % 3) != 0;
            if (out_valid && out_ready) begin
                w[k] = out_word; e[k] = out_err; z[k] = out_zero; l[k] = out_last;
                k++;
            end
            guard++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(k == 2, "R3", {tag, " two result words"}, k, 2);
        if (k == 2) begin
            expect_res(nt, em, ev, ez);
            if (exp_err) begin
                em = 0; ev = 0; ez = 1'b0;
            end
            check(l[0] == 1'b0 && l[1] == 1'b1, "R3", {tag, " last order"}, {l[0], l[1]}, 1);
            check(e[0] == exp_err && e[1] == exp_err, exp_err ? "R6" : "R1",
                  {tag, " err flag"}, e[0], exp_err);
            check(z[0] == ez && z[1] == ez, "R8", {tag, " zero flag"}, z[0], ez);
            check($signed(w[0]) == em, "R4", {tag, " mean"}, $signed(w[0]), em);
            check(int'(w[1]) == ev, "R5", {tag, " variance"}, int'(w[1]), ev);
        end
        check(in_ready == 1'b1, "R9", {tag, " ready after result"}, in_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not end actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        n_chk = 0; n_fail = 0; finished = 1'b0;
        rst = 1'b1; in_valid = 1'b0; in_word = '0; in_last = 1'b0; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);

        // R4 R5: one triple, mean 1.5, variance 0.25
        tc[0] = 4; tm[0] = 384; tv[0] = 256;
        run_set(1, 0, 1'b0, "single");
        check(1'b1, "R1", "single set framed", 0, 0);

        // R4 R5: two triples giving mean 2.0 and variance 1.0
        tc[0] = 2; tm[0] = 256; tv[0] = 0;
        tc[1] = 2; tm[1] = 768; tv[1] = 0;
        run_set(2, 0, 1'b0, "pair");

        // R6: closing word on the mean slot
        tc[0] = 3; tm[0] = 100; tv[0] = 10;
        tc[1] = 5; tm[1] = 200; tv[1] = 0;
        run_set(1, 2, 1'b1, "short2");
        // R6: closing word on the count slot
        run_set(1, 1, 1'b1, "short1");

        // R9: a clean set straight after a malformed one
        tc[0] = 2; tm[0] = 256; tv[0] = 0;
        tc[1] = 2; tm[1] = 768; tv[1] = 0;
        run_set(2, 0, 1'b0, "after_err");

        // R7: negative count
        tc[0] = 3; tm[0] = 10; tv[0] = 0;
        tc[1] = -3; tm[1] = 10; tv[1] = 0;
        run_set(2, 0, 1'b1, "negcount");

        // R8: all counts zero
        tc[0] = 0; tm[0] = 500; tv[0] = 40;
        tc[1] = 0; tm[1] = -500; tv[1] = 0;
        run_set(2, 0, 1'b0, "empty");

        // R5: wide spread saturates the variance
        tc[0] = 100; tm[0] = -32512; tv[0] = 0;
        tc[1] = 100; tm[1] = 32512; tv[1] = 0;
        run_set(2, 0, 1'b0, "saturate");

        // random sets, R4 R5 R9
        for (int s = 0; s < 24; s++) begin
            int nt;
            nt = 1 + int'($urandom % 8);
            for (int i = 0; i < nt; i++) begin
                tc[i] = int'($urandom_range(0, 20));
                tm[i] = int'($urandom_range(0, 8000)) - 4000;
                tv[i] = int'($urandom_range(0, 3000));
            end
            run_set(nt, 0, 1'b0, "random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule